// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through SRAM Core

This block is a synchronous single-port memory whose read and write commands may follow each other on every clock with no idle cycle on the data bus. On one clock edge the block registers a command: address, read/write select, per-byte write masks and the three-way select. The data transfer for that command takes place on the next enabled edge. For a write, the data on `dq_in` is captured at that edge. For a read, the word goes straight from the array to `dq_out`, addressed by the registered address, with no output register in between.

A built-in burst address generator lets one loaded address serve a run of beats. The two low address bits then step in either linear or interleaved order. An active-low clock enable freezes all internal state. An asynchronous output enable can turn the bus drivers off at any moment. The tri-state data bus is modelled as separate `dq_in`, `dq_out` and `dq_oe` signals, and `dq_oe` high means the block drives the bus.

Top module: `zt_sram`

## Requirements
- R1: While and right after a synchronous reset (`rst` high), `dq_oe` is 0, no command is pending and no burst is active.
- R2: A load (`adv_ld`=0) with the block selected and `rw`=1 at an enabled edge makes `dq_out` equal the stored word at that address during the following cycle. In that cycle `dq_oe` equals the inverse of `oe_n`.
- R3: A load with `rw`=0 at an enabled edge writes the word on `dq_in` at the next enabled edge. Byte lane n is bits 8n+7..8n together with bit 32+n, and it is written only if `bw_n[n]` was 0 when the command was registered.
- R4: Reads and writes may alternate on every cycle. A read command issued right after a write to the same address returns the newly written word.
- R5: `oe_n`=1 forces `dq_oe` to 0 combinationally, with no clock edge needed.
- R6: When `cen_n`=1 at an edge, every input is ignored and all registers keep their value. A pending transfer stays pending and completes at the next enabled edge.
- R7: The block is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load edge without selection starts no operation and ends any burst, but the transfer that is already pending still completes.
- R8: `dq_oe` is 0 in the cycle after a write command or after a deselecting load.
- R9: `adv_ld`=1 during an active burst issues the burst's loaded operation again at the next beat address, whatever `rw` is. The upper address bits are kept, and the low two bits are (s+k) mod 4 when `lin` was 1 at load (linear) or s XOR k when it was 0 (interleaved). Here s is the loaded low bits and k the beat number.
- R10: `adv_ld`=1 with no burst active (after reset or after a deselect) starts no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high stalls the block |
| ce1_n | input | 1 | Select, active low |
| ce2 | input | 1 | Select, active high |
| ce3_n | input | 1 | Select, active low |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| rw | input | 1 | 1 read, 0 write |
| bw_n | input | 4 | Byte-lane write enables, active low |
| addr | input | AW | Word address |
| lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data towards the bus |
| dq_oe | output | 1 | High while the block drives the bus |

## Verification
The main function is tried with single reads and writes alternating every cycle, including a read that directly follows a write to the same address. These patterns separate a design that forwards or lands the write in time from one that returns stale data or inserts a gap. Write bursts in linear order are followed by read bursts in interleaved and linear order from different start offsets, so each order produces a distinct address sequence. Masked writes, stalls that fall on pending reads and writes, and each select input dropped on its own show that lanes, held state and deselects act separately.

// File: rtl/zt_pkg.sv
package zt_pkg;

    localparam int WORD_W = 36;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        XFER_NONE  = 2'd0,
        XFER_READ  = 2'd1,
        XFER_WRITE = 2'd2
    } xfer_e;

    typedef struct packed {
        xfer_e            op;
        logic [LANES-1:0] bw_n;
    } cmd_t;

    // Low address bits of beat k for a burst that started at offset s.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        return linear ? (start + beat) : (start ^ beat);
    endfunction

    function automatic logic [LANE_W-1:0] lane_get(
        input logic [WORD_W-1:0] word,
        input int                n
    );
        return {word[LANES*BYTE_W + n], word[n*BYTE_W +: BYTE_W]};
    endfunction

endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
    import zt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_sel,
    input  logic          load_go,
    input  logic          adv_go,
    input  logic          lin_in,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_nxt
);

    logic [AW-1:0]     base_q;
    logic [BEAT_W-1:0] beat_q;
    logic              lin_q;
    logic [BEAT_W-1:0] beat_inc;

    assign beat_inc = beat_q + BEAT_W'(1);

    always_comb begin
        if (load_sel) begin
            addr_nxt = addr_in;
        end else begin
            addr_nxt = {base_q[AW-1:BEAT_W],
                        beat_offset(base_q[BEAT_W-1:0], beat_inc, lin_q)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            lin_q  <= 1'b1;
        end else if (load_go) begin
            base_q <= addr_in;
            beat_q <= '0;
            lin_q  <= lin_in;
        end else if (adv_go) begin
            beat_q <= beat_inc;
        end
    end

endmodule

// File: rtl/zt_ctrl.sv
module zt_ctrl
    import zt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cen_n,
    input  logic             sel,
    input  logic             adv_ld,
    input  logic             rw,
    input  logic [LANES-1:0] bw_n,
    input  logic [AW-1:0]    addr_nxt,
    output logic             load_go,
    output logic             adv_go,
    output cmd_t             pend,
    output logic [AW-1:0]    pend_addr
);

    logic  en;
    logic  burst_q;
    xfer_e burst_op_q;
    xfer_e op_nxt;

    assign en      = !cen_n;
    assign load_go = en && !adv_ld && sel;
    assign adv_go  = en && adv_ld && burst_q;

    always_comb begin
        op_nxt = XFER_NONE;
        if (!adv_ld) begin
            if (sel) op_nxt = rw ? XFER_READ : XFER_WRITE;
        end else if (burst_q) begin
            op_nxt = burst_op_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_q    <= 1'b0;
            burst_op_q <= XFER_NONE;
            pend.op    <= XFER_NONE;
            pend.bw_n  <= '1;
            pend_addr  <= '0;
        end else if (en) begin
            if (!adv_ld) begin
                burst_q    <= sel;
                burst_op_q <= op_nxt;
            end
            pend.op   <= op_nxt;
            pend.bw_n <= bw_n;
            pend_addr <= addr_nxt;
        end
    end

endmodule

// File: rtl/zt_array.sv
module zt_array
    import zt_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  wmask_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_lane;

        always_ff @(posedge clk) begin
            if (we && !wmask_n[g]) mem[addr] <= lane_get(wdata, g);
        end

        assign rd_lane = mem[addr];
        assign rdata[g*BYTE_W +: BYTE_W]  = rd_lane[BYTE_W-1:0];
        assign rdata[LANES*BYTE_W + g]    = rd_lane[BYTE_W];
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adv_ld,
    input  logic              rw,
    input  logic [3:0]        bw_n,
    input  logic [AW-1:0]     addr,
    input  logic              lin,
    input  logic              oe_n,
    input  logic [35:0]       dq_in,
    output logic [35:0]       dq_out,
    output logic              dq_oe
);

    logic          sel;
    logic          load_go;
    logic          adv_go;
    logic [AW-1:0] addr_nxt;
    cmd_t          pend;
    logic [AW-1:0] pend_addr;
    logic          wr_fire;

    assign sel = !ce1_n && ce2 && !ce3_n;

    zt_burst_gen #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .load_sel (!adv_ld),
        .load_go  (load_go),
        .adv_go   (adv_go),
        .lin_in   (lin),
        .addr_in  (addr),
        .addr_nxt (addr_nxt)
    );

    zt_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cen_n     (cen_n),
        .sel       (sel),
        .adv_ld    (adv_ld),
        .rw        (rw),
        .bw_n      (bw_n),
        .addr_nxt  (addr_nxt),
        .load_go   (load_go),
        .adv_go    (adv_go),
        .pend      (pend),
        .pend_addr (pend_addr)
    );

    assign wr_fire = !cen_n && (pend.op == XFER_WRITE);

    zt_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk     (clk),
        .we      (wr_fire),
        .wmask_n (pend.bw_n),
        .addr    (pend_addr),
        .wdata   (dq_in),
        .rdata   (dq_out)
    );

    assign dq_oe = (pend.op == XFER_READ) && !oe_n;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cen_n,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          adv_ld,
    input logic          rw,
    input logic          oe_n,
    input logic [35:0]   dq_out,
    input logic          dq_oe
);

    logic sel_in;
    assign sel_in = !ce1_n && ce2 && !ce3_n;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !dq_oe);                                         // R1

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld && sel_in && rw) |=> (dq_oe == !oe_n)); // R2

    AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);                                        // R5

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> $stable(dq_out));                              // R6

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld && !sel_in) |=> !dq_oe);              // R7

    AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld && sel_in && !rw) |=> !dq_oe);        // R8

endmodule

bind zt_sram zt_sram_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cen_n  (cen_n),
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .ce3_n  (ce3_n),
    .adv_ld (adv_ld),
    .rw     (rw),
    .oe_n   (oe_n),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int NV         = 37;
    localparam logic [2:0] SEL = 3'b010;   // {ce1_n, ce2, ce3_n}
    localparam logic [2:0] DES = 3'b110;

    typedef struct packed {
        logic        cen_n;
        logic [2:0]  ce;
        logic        adv;
        logic        rw;
        logic [3:0]  bw;
        logic [7:0]  addr;
        logic        lin;
        logic        oe_n;
        logic [35:0] din;
        logic        wflag;
        logic [3:0]  wmask;
        logic [7:0]  waddr;
        logic        exp_oe;
        logic [7:0]  exp_addr;
    } vec_t;

    // cen_n ce adv rw bw addr lin oe_n din wflag wmask waddr exp_oe exp_addr
    localparam vec_t VEC [NV] = '{
        '{1'b0, SEL, 1'b0, 1'b0, 4'h0, 8'h10, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k0  write 10
        '{1'b0, SEL, 1'b0, 1'b0, 4'h0, 8'h11, 1'b1, 1'b0, 36'h1_1111_1110, 1'b1, 4'hF, 8'h10, 1'b0, 8'h00}, // k1  write 11
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h10, 1'b1, 1'b0, 36'h2_2222_2221, 1'b1, 4'hF, 8'h11, 1'b1, 8'h10}, // k2  read 10
        '{1'b0, SEL, 1'b0, 1'b0, 4'h0, 8'h12, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k3  write 12
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h12, 1'b1, 1'b0, 36'h3_3333_3332, 1'b1, 4'hF, 8'h12, 1'b1, 8'h12}, // k4  read 12 same addr
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h11, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h11}, // k5  read 11
        '{1'b0, DES, 1'b0, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k6  deselect
        '{1'b0, SEL, 1'b1, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k7  adv, no burst
        '{1'b0, SEL, 1'b0, 1'b0, 4'h0, 8'h21, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k8  write burst 21 lin
        '{1'b0, SEL, 1'b1, 1'b1, 4'h0, 8'h00, 1'b1, 1'b0, 36'h4_0000_0021, 1'b1, 4'hF, 8'h21, 1'b0, 8'h00}, // k9  adv -> 22
        '{1'b0, SEL, 1'b1, 1'b1, 4'h0, 8'h00, 1'b1, 1'b0, 36'h4_0000_0022, 1'b1, 4'hF, 8'h22, 1'b0, 8'h00}, // k10 adv -> 23
        '{1'b0, SEL, 1'b1, 1'b1, 4'h0, 8'h00, 1'b1, 1'b0, 36'h4_0000_0023, 1'b1, 4'hF, 8'h23, 1'b0, 8'h00}, // k11 adv -> 20
        '{1'b0, DES, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 36'h4_0000_0020, 1'b1, 4'hF, 8'h20, 1'b0, 8'h00}, // k12 deselect
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h22, 1'b0, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h22}, // k13 read burst 22 intl
        '{1'b0, SEL, 1'b1, 1'b1, 4'hF, 8'h00, 1'b0, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h23}, // k14
        '{1'b0, SEL, 1'b1, 1'b1, 4'hF, 8'h00, 1'b0, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h20}, // k15
        '{1'b0, SEL, 1'b1, 1'b1, 4'hF, 8'h00, 1'b0, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h21}, // k16
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h23, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h23}, // k17 read burst 23 lin
        '{1'b0, SEL, 1'b1, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h20}, // k18
        '{1'b0, SEL, 1'b1, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h21}, // k19
        '{1'b0, SEL, 1'b0, 1'b0, 4'hA, 8'h10, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k20 masked write 10
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h10, 1'b1, 1'b0, 36'hF_FFFF_FFFF, 1'b1, 4'h5, 8'h10, 1'b1, 8'h10}, // k21 read back
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h11, 1'b1, 1'b1, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k22 read, oe_n high
        '{1'b1, SEL, 1'b0, 1'b0, 4'h0, 8'h30, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h11}, // k23 stall holds read
        '{1'b0, DES, 1'b0, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k24 deselect
        '{1'b0, SEL, 1'b0, 1'b0, 4'h0, 8'h30, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k25 write 30
        '{1'b1, SEL, 1'b0, 1'b1, 4'hF, 8'h31, 1'b1, 1'b0, 36'h0_DEAD_BEEF, 1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k26 stall on write
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h30, 1'b1, 1'b0, 36'h5_A5A5_A5A5, 1'b1, 4'hF, 8'h30, 1'b1, 8'h30}, // k27 read 30
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h22, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h22}, // k28 read burst 22
        '{1'b0, DES, 1'b0, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k29 deselect
        '{1'b0, SEL, 1'b1, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k30 adv after stop
        '{1'b0, 3'b110, 1'b0, 1'b1, 4'hF, 8'h10, 1'b1, 1'b0, 36'h0,        1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k31 ce1_n high
        '{1'b0, 3'b000, 1'b0, 1'b1, 4'hF, 8'h10, 1'b1, 1'b0, 36'h0,        1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k32 ce2 low
        '{1'b0, 3'b011, 1'b0, 1'b1, 4'hF, 8'h10, 1'b1, 1'b0, 36'h0,        1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k33 ce3_n high
        '{1'b0, SEL, 1'b0, 1'b0, 4'h0, 8'h40, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b0, 8'h00}, // k34 write 40
        '{1'b0, DES, 1'b0, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0, 36'h6_0000_0040, 1'b1, 4'hF, 8'h40, 1'b0, 8'h00}, // k35 deselect, write lands
        '{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h40, 1'b1, 1'b0, 36'h0,           1'b0, 4'h0, 8'h00, 1'b1, 8'h40}  // k36 read 40
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cen_n = 1'b0;
    logic        ce1_n = 1'b1;
    logic        ce2 = 1'b1;
    logic        ce3_n = 1'b0;
    logic        adv_ld = 1'b0;
    logic        rw = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic [7:0]  addr = '0;
    logic        lin = 1'b1;
    logic        oe_n = 1'b0;
    logic [35:0] dq_in = '0;
    logic [35:0] dq_out;
    logic        dq_oe;

    logic [35:0] ref_mem [DEPTH];
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zt_sram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld(adv_ld), .rw(rw), .bw_n(bw_n), .addr(addr),
        .lin(lin), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check_oe(input string req, input logic exp);
        n_checks++;
        if (dq_oe !== exp) begin
            n_fail++;
            $display("FAIL %s: dq_oe actual %b expected %b", req, dq_oe, exp);
        end
    endtask

    task automatic check_word(input string req, input logic exp_oe, input logic [35:0] exp);
        n_checks++;
        if (dq_oe !== exp_oe || (exp_oe && dq_out !== exp)) begin
            n_fail++;
            $display("FAIL %s: oe/data actual %b/%h expected %b/%h",
                     req, dq_oe, dq_out, exp_oe, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cen_n  = v.cen_n;
        {ce1_n, ce2, ce3_n} = v.ce;
        adv_ld = v.adv;
        rw     = v.rw;
        bw_n   = v.bw;
        addr   = v.addr;
        lin    = v.lin;
        oe_n   = v.oe_n;
        dq_in  = v.din;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_oe("R1 in reset", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_oe("R1 after reset", 1'b0);

        // Table walk: R2 R3 R4 R6 R7 R8 R9 R10
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            apply(VEC[k]);
            if (VEC[k].wflag) begin
                for (int n = 0; n < 4; n++) begin
                    if (VEC[k].wmask[n]) begin
                        ref_mem[VEC[k].waddr][n*8 +: 8] = VEC[k].din[n*8 +: 8];
                        ref_mem[VEC[k].waddr][32+n]     = VEC[k].din[32+n];
                    end
                end
            end
            @(posedge clk);
            #1;
            check_word($sformatf("R2/R3/R4/R6/R7/R8/R9 vec %0d", k),
                       VEC[k].exp_oe, ref_mem[VEC[k].exp_addr]);
        end

        // R5: oe_n acts without a clock edge
        @(negedge clk);
        apply('{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h12, 1'b1, 1'b0, 36'h0,
                1'b0, 4'h0, 8'h00, 1'b0, 8'h00});
        @(posedge clk);
        #1;
        check_word("R5 read driven", 1'b1, ref_mem[8'h12]);
        cen_n = 1'b1;
        #1;
        oe_n = 1'b1;
        #1;
        check_oe("R5 async off", 1'b0);
        oe_n = 1'b0;
        #1;
        check_oe("R5 async on", 1'b1);

        // R1 / R10: reset in a burst, then advance starts nothing
        @(negedge clk);
        cen_n = 1'b0;
        apply('{1'b0, SEL, 1'b0, 1'b1, 4'hF, 8'h20, 1'b1, 1'b0, 36'h0,
                1'b0, 4'h0, 8'h00, 1'b0, 8'h00});
        @(posedge clk);
        #1;
        check_word("R2 burst start", 1'b1, ref_mem[8'h20]);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_oe("R1 reset mid burst", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        adv_ld = 1'b1;
        @(posedge clk);
        #1;
        check_oe("R10 adv after reset", 1'b0);

        @(negedge clk);
        finish_run();
    end

endmodule